// File: doc/BRIEF.md
# Configurable Serial Character Receiver with Error Filtering

This block receives asynchronous serial characters from a single line and places them in a small receive queue. The line is oversampled with a strobe that runs at sixteen times the bit rate. The block confirms each start bit, then assembles a character of 5 to 8 bits, least significant bit first. It can check an optional parity bit and always checks the first stop bit. The character length, the parity mode, the line polarity and the error policy are all set at run time through configuration inputs.

A character with a parity or framing error produces a one-cycle error pulse. A policy input decides whether such a character is still stored or is thrown away. A loopback selector feeds the local transmitter's output into the receiver in place of the external line. A synchronous clear empties the queue. Software reads the queue through a show-ahead port. The word at the head is always visible, and a read strobe removes it.

Top module: `uart_rx_filter`

## Requirements
- R1: `cfg_char_len` selects the character size: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. The stored byte carries the character in its low bits, and every bit above the character size is 0.
- R2: When `cfg_par_en` is 1, one parity bit follows the data bits. `cfg_par_odd` = 0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch raises `par_err_pulse` high for exactly one cycle. When `cfg_par_en` is 0, no parity bit is expected and `par_err_pulse` stays low.
- R3: When `cfg_rx_inv` is 1, the selected line is inverted before start detection and sampling. An inverted frame is then received with the same data as a normal one.
- R4: When `cfg_drop_bad` is 1, a character with a parity or framing error is not written to the queue. When it is 0, such a character is written like a good one.
- R5: When `cfg_loopback` is 1, the receiver takes its input from `tx_loop` and ignores `rxd`.
- R6: A cycle with `fifo_clr` high leaves the queue empty on the next cycle.
- R7: A low level starts a frame only if the line is still low 8 strobes later, at the middle of the start bit. A shorter low pulse stores nothing and raises no pulse.
- R8: A first stop bit sampled low is a framing error. It raises `frm_err_pulse` high for exactly one cycle.
- R9: A character to be stored while the queue holds `DEPTH` entries is discarded, and `ovf_pulse` goes high for one cycle. The entries already in the queue are unchanged.
- R10: The queue keeps arrival order. `rd_data` shows the oldest entry, and `rd_en` removes it. `fifo_empty` and `fifo_full` report zero and `DEPTH` entries, and both are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | External serial line |
| tx_loop | input | 1 | Local transmitter output, used in loopback |
| cfg_char_len | input | 2 | Character size code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| cfg_rx_inv | input | 1 | Invert the received line |
| cfg_drop_bad | input | 1 | Discard characters that have errors |
| cfg_loopback | input | 1 | Receive from tx_loop instead of rxd |
| fifo_clr | input | 1 | Synchronous queue clear |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry of the queue |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| par_err_pulse | output | 1 | Parity error, one cycle |
| frm_err_pulse | output | 1 | Framing error, one cycle |
| ovf_pulse | output | 1 | Character lost because the queue was full |

## Verification
The bound checker watches, on every cycle, the relations that hold at all times. It checks that the queue flags exclude each other, that a clear empties the queue, that each error pulse lasts one cycle, that an overflow pulse only follows a full queue, and that an errored character never enters an empty queue while dropping is enabled. The bench's frame scenarios are needed for the rest: the data value and zero fill for each character size, parity in both modes, inversion, loopback with a hostile `rxd`, a runt start pulse, and arrival order across an overflow. The bench's model predicts the queue contents and the pulse totals.

// File: rtl/uart_rx_filter.sv
module uart_rx_filter #(
  parameter int DEPTH = 8,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       tx_loop,
  input  logic [1:0] cfg_char_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_rx_inv,
  input  logic       cfg_drop_bad,
  input  logic       cfg_loopback,
  input  logic       fifo_clr,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       fifo_empty,
  output logic       fifo_full,
  output logic       par_err_pulse,
  output logic       frm_err_pulse,
  output logic       ovf_pulse
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] FULL_BIT = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF_BIT = CW'(OSR / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          pbit;
  logic          line, mid, done, ferr, perr, keep, wr, rd;
  logic [7:0]    char_w;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   used;

  assign line   = sync[1];
  assign mid    = baud_tick && cnt == FULL_BIT;
  assign done   = st == S_STOP && mid;
  assign char_w = sh >> (2'd3 - cfg_char_len);
  assign ferr   = done && !line;
  assign perr   = done && cfg_par_en && ((^char_w ^ pbit) != cfg_par_odd);
  assign keep   = done && !(cfg_drop_bad && (ferr || perr));
  assign wr     = keep && !fifo_full;
  assign rd     = rd_en && !fifo_empty;

  assign fifo_empty = used == '0;
  assign fifo_full  = used == (AW+1)'(DEPTH);
  assign rd_data    = mem[rp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], (cfg_loopback ? tx_loop : rxd) ^ cfg_rx_inv};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (baud_tick) begin
      cnt <= (cnt == FULL_BIT) ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!line) st <= S_START;
        end
        S_START:
          if (cnt == HALF_BIT) begin
            cnt  <= '0;
            bitn <= '0;
            st   <= line ? S_IDLE : S_DATA;
          end
        S_DATA:
          if (mid) begin
            sh   <= {line, sh[7:1]};
            bitn <= bitn + 1'b1;
            if (bitn == {1'b0, cfg_char_len} + 3'd4)
              st <= cfg_par_en ? S_PAR : S_STOP;
          end
        S_PAR:
          if (mid) begin
            pbit <= line;
            st   <= S_STOP;
          end
        S_STOP:
          if (mid) st <= line ? S_IDLE : S_BRK;
        default: begin
          cnt <= '0;
          if (line) st <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      par_err_pulse <= 1'b0;
      frm_err_pulse <= 1'b0;
      ovf_pulse     <= 1'b0;
    end else begin
      par_err_pulse <= perr;
      frm_err_pulse <= ferr;
      ovf_pulse     <= keep && fifo_full;
    end

  always_ff @(posedge clk)
    if (wr) mem[wp] <= char_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else if (fifo_clr) begin
      wp   <= '0;
      rp   <= '0;
      used <= '0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      used <= used + (AW+1)'(wr) - (AW+1)'(rd);
    end
endmodule

// File: rtl/uart_rx_filter_chk.sv
module uart_rx_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_drop_bad,
  input logic       fifo_clr,
  input logic       fifo_empty,
  input logic       fifo_full,
  input logic       par_err_pulse,
  input logic       frm_err_pulse,
  input logic       ovf_pulse
);
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> fifo_empty);

  assert_par_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_pulse |=> !par_err_pulse);

  assert_frm_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err_pulse |=> !frm_err_pulse);

  assert_ovf_after_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(fifo_full));

  assert_drop_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_pulse || frm_err_pulse) && $past(cfg_drop_bad) && $past(fifo_empty)
      && !$past(fifo_clr) |-> fifo_empty);
endmodule

bind uart_rx_filter uart_rx_filter_chk u_chk (.*);

// File: tb/uart_rx_filter_tb.sv
`timescale 1ns/1ps
module uart_rx_filter_tb;
  localparam int DEPTH = 8;
  localparam int TPB   = 4;
  localparam int BIT_CLKS = 16 * TPB;

  logic clk = 0, rst_n = 0, baud_tick = 0, rxd = 1, tx_loop = 1;
  logic [1:0] cfg_char_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_rx_inv = 0, cfg_drop_bad = 0, cfg_loopback = 0;
  logic fifo_clr = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic fifo_empty, fifo_full, par_err_pulse, frm_err_pulse, ovf_pulse;

  int errors = 0, checks = 0;
  int seen_perr = 0, seen_ferr = 0, seen_ovf = 0;
  int exp_perr = 0, exp_ferr = 0, exp_ovf = 0;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  uart_rx_filter #(.DEPTH(DEPTH), .OSR(16)) u_dut (.*);

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv <= (tdiv == TPB - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TPB - 1);
  end

  always @(posedge clk) if (rst_n) begin
    if (par_err_pulse) seen_perr++;
    if (frm_err_pulse) seen_ferr++;
    if (ovf_pulse)     seen_ovf++;
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic drive(logic v);
    logic p = v ^ cfg_rx_inv;
    if (cfg_loopback) tx_loop = p; else rxd = p;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, bit bad_par, bit bad_stop);
    int n = int'(cfg_char_len) + 5;
    logic [7:0] m = d & ((8'd1 << n) - 1);
    logic p = (^m) ^ cfg_par_odd ^ bad_par;
    bit bad;
    drive(1'b0);
    for (int i = 0; i < n; i++) drive(m[i]);
    if (cfg_par_en) drive(p);
    drive(!bad_stop);
    drive(1'b1);
    drive(1'b1);
    bad = (bad_par && cfg_par_en) || bad_stop;
    if (bad_par && cfg_par_en) exp_perr++;
    if (bad_stop) exp_ferr++;
    if (!(cfg_drop_bad && bad)) begin
      if (q.size() == DEPTH) exp_ovf++;
      else q.push_back(m);
    end
  endtask

  task automatic pulses(string r);
    chk({r, " parity pulses"}, seen_perr, exp_perr);
    chk({r, " framing pulses"}, seen_ferr, exp_ferr);
    chk({r, " overflow pulses"}, seen_ovf, exp_ovf);
  endtask

  task automatic drain(string r);
    chk({r, " R10 fill level"}, int'(fifo_empty), int'(q.size() == 0));
    chk({r, " R10 full flag"}, int'(fifo_full), int'(q.size() == DEPTH));
    while (q.size() > 0) begin
      logic [7:0] e = q.pop_front();
      chk({r, " R10 data"}, int'(rd_data), int'(e));
      if (fifo_empty) begin
        q.delete();
        break;
      end
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
    end
    chk({r, " R10 empty after drain"}, int'(fifo_empty), 1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R10 reset empty", int'(fifo_empty), 1);
    chk("R10 reset full", int'(fifo_full), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    send(8'hA5, 0, 0); send(8'h3C, 0, 0); send(8'h01, 0, 0);
    pulses("R1 8-bit"); drain("R1 8-bit");

    cfg_char_len = 2'd0; send(8'hF5, 0, 0); send(8'hEA, 0, 0);
    cfg_char_len = 2'd1; send(8'hFF, 0, 0);
    cfg_char_len = 2'd2; send(8'hD3, 0, 0);
    pulses("R1 short"); drain("R1 short upper zero");

    cfg_char_len = 2'd3; cfg_par_en = 1;
    cfg_par_odd = 0; send(8'h37, 0, 0); send(8'h36, 0, 0);
    cfg_par_odd = 1; send(8'h37, 0, 0); send(8'h80, 0, 0);
    pulses("R2 good parity"); drain("R2 good parity");

    cfg_drop_bad = 0; send(8'h5A, 1, 0);
    pulses("R2 bad parity"); drain("R4 kept when drop off");
    cfg_drop_bad = 1; send(8'h5B, 1, 0); send(8'h11, 0, 0);
    pulses("R2 R4 drop"); drain("R4 dropped parity error");

    cfg_par_en = 0;
    cfg_drop_bad = 0; send(8'h77, 0, 1);
    pulses("R8 framing kept"); drain("R8 R4 kept");
    cfg_drop_bad = 1; send(8'h78, 0, 1); send(8'h22, 0, 0);
    pulses("R8 framing drop"); drain("R4 dropped framing");
    cfg_drop_bad = 0;

    cfg_rx_inv = 1; rxd = 0;
    repeat (3 * BIT_CLKS) @(negedge clk);
    send(8'hC3, 0, 0); send(8'h0F, 0, 0);
    pulses("R3 invert"); drain("R3 invert");
    cfg_rx_inv = 0; rxd = 1;
    repeat (3 * BIT_CLKS) @(negedge clk);

    tx_loop = 1; cfg_loopback = 1; rxd = 0;
    repeat (3 * BIT_CLKS) @(negedge clk);
    send(8'h96, 0, 0); send(8'h69, 0, 0);
    pulses("R5 loopback"); drain("R5 loopback ignores rxd");
    rxd = 1; cfg_loopback = 0;
    repeat (3 * BIT_CLKS) @(negedge clk);

    rxd = 0; repeat (4 * TPB) @(negedge clk);
    rxd = 1; repeat (3 * BIT_CLKS) @(negedge clk);
    pulses("R7 runt start"); drain("R7 runt stores nothing");

    for (int i = 0; i < DEPTH + 2; i++) send(8'(8'h40 + i), 0, 0);
    pulses("R9 overflow"); drain("R9 order kept");

    send(8'h12, 0, 0); send(8'h34, 0, 0);
    chk("R6 pre-clear not empty", int'(fifo_empty), 0);
    fifo_clr = 1; @(negedge clk); fifo_clr = 0;
    q.delete();
    chk("R6 cleared", int'(fifo_empty), 1);
    send(8'h56, 0, 0);
    pulses("R6 after clear"); drain("R6 after clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule